// File: doc/BRIEF.md
# Descriptor-Chained Lookup-Table Refill Engine

This block rewrites a rectangular patch of a two-dimensional translation table. Software builds a chain of descriptors in memory. Each descriptor names a rectangle of table slots, a control word and a pointer to a buffer of 32-bit entries. Software then writes the address of the first descriptor into the head register. The engine reads each descriptor through a single-outstanding memory read port, in which data returns one cycle after the request. It then streams that rectangle's entries into the table, one slot per entry, and follows the next pointer until it reaches a null pointer.

Progress is reported in a status word and in an 8-bit interrupt status field. The status word has ready, valid, done and error flags. The interrupt field has per-descriptor, end-of-chain, bounds-error and alignment-error events. The field is cleared by writing back the bits that were read, and is gated onto a single interrupt line by an enable mask that has separate set and clear registers. Two read-only registers report the build-time engine and table counts and the table geometry.

Top module: `refill_engine`

## Requirements
- R1: After reset the status word reads 0x1 (bit 0 ready; bits 1 valid, 2 done and 3 error are clear), the interrupt status and enable registers read 0, and `irq` is low.
- R2: The info register (offset 6) reads the engine count in bits [28:24] and the table count in bits [20:16]. The geometry register (offset 7) reads the table width in bits [19:16] and the height in bits [27:24], each in units of 32 slots.
- R3: A descriptor is five 32-bit words at byte offsets 0, 4, 8, 12 and 16. These are {y0,x0}, {y1,x1} (16 bits each, with x in the low half), control (bit 0 start, bits [11:8] table id), the data pointer and the next pointer. The table id is presented on `tbl_lut` for each write.
- R4: Each slot of the rectangle takes the next consecutive 32-bit word of the data buffer. Slots are written in row-major order, with x running fastest from x0 to x1 and then y advancing from y0 to y1.
- R5: A nonzero next pointer is followed, and a zero next pointer ends the chain. On completion the status reads 0x7. Interrupt status bit 0 is set for each descriptor finished and bit 1 is set at the end of the chain. While a walk is running, status bit 0 reads 0.
- R6: If a descriptor has x1 < x0, y1 < y0, or a corner outside the table, the walk stops with status 0x9 and interrupt status bit 2 set. That descriptor writes no slot.
- R7: A head, data or next pointer whose low four bits are not zero stops the walk with status 0x9 and interrupt status bit 3 set.
- R8: A nonzero head write while a walk is running is ignored, and the running chain completes unchanged.
- R9: A head write of zero stops any walk in the next cycle. Status then reads 0x1 and no further table or memory access is made.
- R10: Interrupt status (offset 2) is write-one-to-clear. Offset 3 sets and offset 4 clears enable bits, and offset 5 reads the enables. `irq` is high exactly while some status bit and its enable are both set.
- R11: A descriptor whose start bit is 0 writes no slot, but still counts as finished and the chain continues to its next pointer.
- R12: Memory reads use 4-byte aligned addresses, with at most one request in any two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Masked interrupt |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| tbl_we | output | 1 | Table write strobe |
| tbl_x | output | 8 | Slot column |
| tbl_y | output | 7 | Slot row |
| tbl_lut | output | 4 | Table id |
| tbl_data | output | 32 | Entry written to the slot |

## Verification
A corrupted coordinate counter or data pointer appears on the very next table write as a wrong slot position or entry. The bench compares every write against a queue built from the descriptors in memory, so the fault is caught in the cycle it happens. A wrong walker state shows up within one descriptor in one of three ways: as a table write or memory read after a cancel, as a chain that never returns to ready, or as a status word that does not read 0x7 or 0x9. A flag register that sets or clears wrongly is visible on `irq` and in the interrupt status readback in the cycle after the event.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_F_REQ,
        ST_F_CAP,
        ST_CHECK,
        ST_E_REQ,
        ST_E_CAP,
        ST_NEXT
    } walk_st_e;

    // register word offsets
    localparam logic [2:0] RA_HEAD    = 3'd0;
    localparam logic [2:0] RA_STAT    = 3'd1;
    localparam logic [2:0] RA_ISTAT   = 3'd2;
    localparam logic [2:0] RA_IEN_SET = 3'd3;
    localparam logic [2:0] RA_IEN_CLR = 3'd4;
    localparam logic [2:0] RA_IEN     = 3'd5;
    localparam logic [2:0] RA_INFO    = 3'd6;
    localparam logic [2:0] RA_GEOM    = 3'd7;

    // interrupt status bit positions
    localparam int IRQ_DESC  = 0;
    localparam int IRQ_LAST  = 1;
    localparam int IRQ_BOUND = 2;
    localparam int IRQ_ALIGN = 3;

    localparam int DESC_WORDS = 5;

endpackage

// File: rtl/refill_walker.sv
module refill_walker
    import refill_pkg::*;
#(
    parameter int W_UNITS = 8,
    parameter int H_UNITS = 4,
    parameter int LUT_W   = 4,
    localparam int TBL_W  = W_UNITS * 32,
    localparam int TBL_H  = H_UNITS * 32,
    localparam int X_W    = $clog2(TBL_W),
    localparam int Y_W    = $clog2(TBL_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_wr,
    input  logic [31:0]      head_addr,
    output logic             rd_en,
    output logic [31:0]      rd_addr,
    input  logic [31:0]      rd_data,
    output logic             tbl_we,
    output logic [X_W-1:0]   tbl_x,
    output logic [Y_W-1:0]   tbl_y,
    output logic [LUT_W-1:0] tbl_lut,
    output logic [31:0]      tbl_data,
    output logic [3:0]       stat,
    output logic [3:0]       ev
);

    typedef struct packed {
        walk_st_e         st;
        logic [31:0]      base;
        logic [2:0]       widx;
        logic [15:0]      x0, y0, x1, y1;
        logic             go;
        logic [LUT_W-1:0] lut;
        logic [31:0]      dptr;
        logic [31:0]      nxt;
        logic [15:0]      cx, cy;
        logic             valid, done, err;
    } wk_t;

    wk_t q, d;
    logic bad_rect;

    assign bad_rect = (q.x1 < q.x0) || (q.y1 < q.y0) ||
                      (32'(q.x1) >= TBL_W) || (32'(q.y1) >= TBL_H);

    always_comb begin
        d       = q;
        ev      = '0;
        rd_en   = 1'b0;
        rd_addr = '0;
        tbl_we  = 1'b0;
        unique case (q.st)
            ST_IDLE: ;
            ST_F_REQ: begin
                rd_en   = 1'b1;
                rd_addr = q.base + {27'b0, q.widx, 2'b00};
                d.st    = ST_F_CAP;
            end
            ST_F_CAP: begin
                case (q.widx)
                    3'd0: {d.y0, d.x0} = rd_data;
                    3'd1: {d.y1, d.x1} = rd_data;
                    3'd2: begin
                        d.go  = rd_data[0];
                        d.lut = rd_data[8 +: LUT_W];
                    end
                    3'd3: d.dptr = rd_data;
                    default: d.nxt = rd_data;
                endcase
                if (q.widx == 3'(DESC_WORDS - 1)) begin
                    d.st = ST_CHECK;
                end else begin
                    d.widx = q.widx + 3'd1;
                    d.st   = ST_F_REQ;
                end
            end
            ST_CHECK: begin
                if (!q.go) begin
                    d.st = ST_NEXT;
                end else if (bad_rect) begin
                    d.st = ST_IDLE;
                    d.err = 1'b1;
                    ev[IRQ_BOUND] = 1'b1;
                end else if (q.dptr[3:0] != 4'd0) begin
                    d.st = ST_IDLE;
                    d.err = 1'b1;
                    ev[IRQ_ALIGN] = 1'b1;
                end else begin
                    d.cx = q.x0;
                    d.cy = q.y0;
                    d.st = ST_E_REQ;
                end
            end
            ST_E_REQ: begin
                rd_en   = 1'b1;
                rd_addr = q.dptr;
                d.st    = ST_E_CAP;
            end
            ST_E_CAP: begin
                tbl_we = 1'b1;
                d.dptr = q.dptr + 32'd4;
                d.st   = ST_E_REQ;
                if (q.cx == q.x1) begin
                    d.cx = q.x0;
                    d.cy = q.cy + 16'd1;
                    if (q.cy == q.y1) d.st = ST_NEXT;
                end else begin
                    d.cx = q.cx + 16'd1;
                end
            end
            ST_NEXT: begin
                ev[IRQ_DESC] = 1'b1;
                if (q.nxt == 32'd0) begin
                    d.st = ST_IDLE;
                    d.valid = 1'b1;
                    d.done = 1'b1;
                    ev[IRQ_LAST] = 1'b1;
                end else if (q.nxt[3:0] != 4'd0) begin
                    d.st = ST_IDLE;
                    d.err = 1'b1;
                    ev[IRQ_ALIGN] = 1'b1;
                end else begin
                    d.base = q.nxt;
                    d.widx = 3'd0;
                    d.st   = ST_F_REQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // head register write overrides the walk
        if (head_wr) begin
            if (head_addr == 32'd0) begin
                d.st = ST_IDLE;
                d.valid = 1'b0;
                d.done = 1'b0;
                d.err = 1'b0;
            end else if (q.st == ST_IDLE) begin
                d.valid = 1'b0;
                d.done = 1'b0;
                if (head_addr[3:0] != 4'd0) begin
                    d.err = 1'b1;
                    ev[IRQ_ALIGN] = 1'b1;
                end else begin
                    d.err  = 1'b0;
                    d.base = head_addr;
                    d.widx = 3'd0;
                    d.st   = ST_F_REQ;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tbl_x    = q.cx[X_W-1:0];
    assign tbl_y    = q.cy[Y_W-1:0];
    assign tbl_lut  = q.lut;
    assign tbl_data = rd_data;
    assign stat     = {q.err, q.done, q.valid, q.st == ST_IDLE};

    assert_tbl_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (q.cx <= q.x1) && (q.cy <= q.y1) && (32'(q.cy) < TBL_H) && (32'(q.cx) < TBL_W));

    assert_rd_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[1:0] == 2'b00));

    assert_rd_spaced_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    assert_cancel_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (head_wr && head_addr == 32'd0) |=> (stat[0] && !rd_en && !tbl_we));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (head_wr && head_addr != 32'd0 && q.st != ST_IDLE && q.st != ST_NEXT)
        |=> $stable(q.base));

    assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat[3] |-> !stat[2] && !stat[1]);

endmodule

// File: rtl/refill_regs.sv
module refill_regs
    import refill_pkg::*;
#(
    parameter int ENGINES = 1,
    parameter int LUTS    = 1,
    parameter int W_UNITS = 8,
    parameter int H_UNITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        head_wr,
    output logic [31:0] head_addr,
    input  logic [3:0]  stat,
    input  logic [3:0]  ev
);

    typedef struct packed {
        logic [7:0] istat;
        logic [7:0] ien;
    } rg_t;

    rg_t q, d;

    always_comb begin
        d = q;
        if (reg_we && reg_addr == RA_ISTAT)   d.istat = q.istat & ~reg_wdata[7:0];
        if (reg_we && reg_addr == RA_IEN_SET) d.ien   = q.ien | reg_wdata[7:0];
        if (reg_we && reg_addr == RA_IEN_CLR) d.ien   = q.ien & ~reg_wdata[7:0];
        d.istat = d.istat | {4'b0, ev};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            RA_STAT:  reg_rdata = {28'b0, stat};
            RA_ISTAT: reg_rdata = {24'b0, q.istat};
            RA_IEN:   reg_rdata = {24'b0, q.ien};
            RA_INFO:  reg_rdata = {3'b0, 5'(ENGINES), 3'b0, 5'(LUTS), 16'b0};
            RA_GEOM:  reg_rdata = {4'b0, 4'(H_UNITS), 4'b0, 4'(W_UNITS), 16'b0};
            default:  reg_rdata = 32'b0;
        endcase
    end

    assign irq       = |(q.istat & q.ien);
    assign head_wr   = reg_we && (reg_addr == RA_HEAD);
    assign head_addr = reg_wdata;

    assert_last_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev[IRQ_LAST] |=> q.istat[IRQ_LAST]);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_ISTAT && ev == 4'b0)
        |=> ((q.istat & $past(reg_wdata[7:0])) == 8'b0));

endmodule

// File: rtl/refill_engine.sv
module refill_engine #(
    parameter int ENGINES = 1,
    parameter int LUTS    = 1,
    parameter int W_UNITS = 8,
    parameter int H_UNITS = 4,
    parameter int LUT_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [2:0]                        reg_addr,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       reg_rdata,
    output logic                              irq,
    output logic                              mem_rd_en,
    output logic [31:0]                       mem_rd_addr,
    input  logic [31:0]                       mem_rd_data,
    output logic                              tbl_we,
    output logic [$clog2(W_UNITS*32)-1:0]     tbl_x,
    output logic [$clog2(H_UNITS*32)-1:0]     tbl_y,
    output logic [LUT_W-1:0]                  tbl_lut,
    output logic [31:0]                       tbl_data
);

    logic        head_wr;
    logic [31:0] head_addr;
    logic [3:0]  stat;
    logic [3:0]  ev;

    refill_regs #(
        .ENGINES (ENGINES),
        .LUTS    (LUTS),
        .W_UNITS (W_UNITS),
        .H_UNITS (H_UNITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .head_wr   (head_wr),
        .head_addr (head_addr),
        .stat      (stat),
        .ev        (ev)
    );

    refill_walker #(
        .W_UNITS (W_UNITS),
        .H_UNITS (H_UNITS),
        .LUT_W   (LUT_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_wr   (head_wr),
        .head_addr (head_addr),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .rd_data   (mem_rd_data),
        .tbl_we    (tbl_we),
        .tbl_x     (tbl_x),
        .tbl_y     (tbl_y),
        .tbl_lut   (tbl_lut),
        .tbl_data  (tbl_data),
        .stat      (stat),
        .ev        (ev)
    );

endmodule

// File: tb/refill_engine_tb.sv
`timescale 1ns/1ps
module refill_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        tbl_we;
    logic [7:0]  tbl_x;
    logic [6:0]  tbl_y;
    logic [3:0]  tbl_lut;
    logic [31:0] tbl_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [31:0] mem [0:1023];
    logic [50:0] exp_q[$];

    always #2 clk = ~clk;

    refill_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .tbl_we(tbl_we), .tbl_x(tbl_x), .tbl_y(tbl_y), .tbl_lut(tbl_lut),
        .tbl_data(tbl_data)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:2]];

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of table writes and memory reads
    always @(negedge clk) begin
        cycles++;
        if (rst_n && mem_rd_en) chk("R12", "read alignment", 64'(mem_rd_addr[1:0]), 64'd0);
        if (rst_n && tbl_we) begin
            if (exp_q.size() == 0) begin
                chk("R4", "unexpected table write", 64'({tbl_lut, tbl_x, tbl_y, tbl_data}), 64'd0);
            end else begin
                chk("R3/R4", "table write", 64'({tbl_lut, tbl_x, tbl_y, tbl_data}), 64'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic reg_write(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            reg_read(3'd1, s);
            if (s[0]) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic put_desc(int a, int x0, int y0, int x1, int y1, bit go, int lut, int dp, int nx);
        mem[a/4]     = {16'(y0), 16'(x0)};
        mem[a/4 + 1] = {16'(y1), 16'(x1)};
        mem[a/4 + 2] = {20'b0, 4'(lut), 7'b0, go};
        mem[a/4 + 3] = 32'(dp);
        mem[a/4 + 4] = 32'(nx);
    endtask

    task automatic put_data(int dp, int n, logic [31:0] seed);
        for (int i = 0; i < n; i++) mem[dp/4 + i] = seed + 32'(i * 7);
    endtask

    // behavioural expectation from the requirements (valid chains only)
    task automatic expect_chain(int head);
        int a = head;
        while (a != 0) begin
            int x0 = int'(mem[a/4][15:0]);
            int y0 = int'(mem[a/4][31:16]);
            int x1 = int'(mem[a/4 + 1][15:0]);
            int y1 = int'(mem[a/4 + 1][31:16]);
            int dp = int'(mem[a/4 + 3]);
            if (mem[a/4 + 2][0]) begin
                for (int y = y0; y <= y1; y++)
                    for (int x = x0; x <= x1; x++) begin
                        exp_q.push_back({mem[a/4 + 2][11:8], 8'(x), 7'(y), mem[dp/4]});
                        dp += 4;
                    end
            end
            a = int'(mem[a/4 + 4]);
        end
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;

        // R1 reset state
        reg_read(3'd1, v); chk("R1", "status", 64'(v), 64'h1);
        reg_read(3'd2, v); chk("R1", "irq status", 64'(v), 64'h0);
        reg_read(3'd5, v); chk("R1", "irq enable", 64'(v), 64'h0);
        chk("R1", "irq line", 64'(irq), 64'h0);

        // R2 info registers
        reg_read(3'd6, v); chk("R2", "info", 64'(v), 64'h0101_0000);
        reg_read(3'd7, v); chk("R2", "geometry", 64'(v), 64'h0408_0000);

        // single descriptor, 3x2 rectangle, table id 2
        put_desc(32'h100, 5, 7, 7, 8, 1'b1, 2, 32'h400, 0);
        put_data(32'h400, 6, 32'hA000_0000);
        expect_chain(32'h100);
        reg_write(3'd0, 32'h100);
        reg_read(3'd1, v); chk("R5", "busy clears ready", 64'(v[0]), 64'h0);
        wait_ready();
        reg_read(3'd1, v); chk("R5", "status after chain", 64'(v), 64'h7);
        reg_read(3'd2, v); chk("R5", "irq status after chain", 64'(v), 64'h3);
        chk("R4", "all slots written", 64'(exp_q.size()), 64'd0);

        // R10 interrupt mask and acknowledge
        chk("R10", "irq masked", 64'(irq), 64'h0);
        reg_write(3'd3, 32'h02);
        chk("R10", "irq enabled", 64'(irq), 64'h1);
        reg_read(3'd5, v); chk("R10", "enable readback", 64'(v), 64'h2);
        reg_write(3'd2, 32'h03);
        reg_read(3'd2, v); chk("R10", "ack clears", 64'(v), 64'h0);
        chk("R10", "irq after ack", 64'(irq), 64'h0);
        reg_write(3'd4, 32'h02);
        reg_read(3'd5, v); chk("R10", "enable cleared", 64'(v), 64'h0);

        // chain of three, middle one not started (R11), last at table edge
        put_desc(32'h200, 0, 0, 1, 1, 1'b1, 1, 32'h500, 32'h220);
        put_data(32'h500, 4, 32'hB000_0000);
        put_desc(32'h220, 10, 3, 12, 3, 1'b0, 1, 32'h600, 32'h240);
        put_data(32'h600, 3, 32'hC000_0000);
        put_desc(32'h240, 253, 127, 255, 127, 1'b1, 3, 32'h640, 0);
        put_data(32'h640, 3, 32'hD000_0000);
        expect_chain(32'h200);
        chk("R11", "expected count", 64'(exp_q.size()), 64'd7);
        reg_write(3'd0, 32'h200);
        wait_ready();
        reg_read(3'd1, v); chk("R5", "chain status", 64'(v), 64'h7);
        reg_read(3'd2, v); chk("R11", "irq status chain", 64'(v), 64'h3);
        chk("R11", "skipped descriptor wrote nothing", 64'(exp_q.size()), 64'd0);
        reg_write(3'd2, 32'hFF);

        // R6 corner beyond table width
        put_desc(32'h300, 250, 0, 256, 0, 1'b1, 0, 32'h400, 0);
        reg_write(3'd0, 32'h300);
        wait_ready();
        reg_read(3'd1, v); chk("R6", "bounds status", 64'(v), 64'h9);
        reg_read(3'd2, v); chk("R6", "bounds irq", 64'(v), 64'h4);
        reg_write(3'd2, 32'hFF);
        // R6 reversed rows
        put_desc(32'h300, 0, 5, 0, 4, 1'b1, 0, 32'h400, 0);
        reg_write(3'd0, 32'h300);
        wait_ready();
        reg_read(3'd1, v); chk("R6", "reversed status", 64'(v), 64'h9);
        reg_write(3'd2, 32'hFF);

        // R7 misaligned head and data pointer
        reg_write(3'd0, 32'h108);
        reg_read(3'd1, v); chk("R7", "head align status", 64'(v), 64'h9);
        reg_read(3'd2, v); chk("R7", "head align irq", 64'(v), 64'h8);
        reg_write(3'd2, 32'hFF);
        put_desc(32'h300, 0, 0, 0, 0, 1'b1, 0, 32'h404, 0);
        reg_write(3'd0, 32'h300);
        wait_ready();
        reg_read(3'd1, v); chk("R7", "data align status", 64'(v), 64'h9);
        reg_read(3'd2, v); chk("R7", "data align irq", 64'(v), 64'h8);
        reg_write(3'd2, 32'hFF);

        // R8 restart while busy is ignored
        put_desc(32'h340, 0, 0, 7, 3, 1'b1, 0, 32'h700, 0);
        put_data(32'h700, 32, 32'hE000_0000);
        put_desc(32'h380, 9, 9, 9, 9, 1'b1, 5, 32'h7C0, 0);
        put_data(32'h7C0, 1, 32'hF000_0000);
        expect_chain(32'h340);
        reg_write(3'd0, 32'h340);
        repeat (5) @(posedge clk);
        reg_write(3'd0, 32'h380);
        wait_ready();
        reg_read(3'd1, v); chk("R8", "first chain completes", 64'(v), 64'h7);
        chk("R8", "no slot from ignored start", 64'(exp_q.size()), 64'd0);
        reg_write(3'd2, 32'hFF);

        // R9 cancel mid-walk
        expect_chain(32'h340);
        reg_write(3'd0, 32'h340);
        repeat (30) @(posedge clk);
        reg_write(3'd0, 32'h0);
        reg_read(3'd1, v); chk("R9", "status after cancel", 64'(v), 64'h1);
        chk("R9", "cancel was mid-walk", 64'(exp_q.size() > 0), 64'd1);
        exp_q.delete();
        repeat (100) @(posedge clk);
        #1;
        reg_read(3'd2, v); chk("R9", "no end-of-chain flag", 64'(v[1]), 64'h0);
        reg_read(3'd1, v); chk("R9", "still ready", 64'(v), 64'h1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule